// File: doc/BRIEF.md
# Seven-bit symbol instruction decoder

This block turns a stream of 7-bit symbols into decoded instruction records. Instructions are bit-packed: their fields run across symbol boundaries. Each instruction still ends on a symbol boundary and is one, two, three, five or six symbols long. The first three bits of the first symbol are a format code. The code fixes the instruction's length, which fields are present and where they sit. The other fields are an opcode, up to two register numbers and a 28-bit constant, and some formats also carry padding bits that must be zero.

Symbols arrive through a valid/ready handshake. Once the last symbol of an instruction has been accepted, the block emits one record for one cycle. The record holds the format code, opcode, source and destination register numbers, constant, length in symbols and an error flag. The fetch logic uses the length to advance its program counter. An instruction with an unknown format code is taken to be one symbol long and is flagged as an error, so decoding starts again at the next symbol. An instruction whose padding bits are not zero is decoded in full and flagged as an error.

Top module: `bitpack_decoder`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are low. The first clock edge after reset release raises in_ready, and from then on in_ready stays high.
- R2: Within each symbol, bits are consumed from bit 6 down to bit 0. Bits 6:4 of an instruction's first symbol are its format code, and out_fmt reports that code.
- R3: out_len gives the instruction length in symbols: 3 for format 2, 6 for format 3, 2 for format 4, 5 for format 5, and 1 for formats 6, 7, 0 and 1.
- R4: Format 2 (register-register) is laid out as: code, a 4-bit opcode, a 4-bit source register, a 4-bit destination register, then 6 padding bits. The record reports out_opcode, out_src and out_dst, and out_const is 0.
- R5: Format 3 (register-constant) is laid out as: code, a 4-bit opcode, a 4-bit destination register, 3 padding bits, then four 7-bit constant symbols. The first of these supplies out_const[6:0] and the last supplies out_const[27:21]. out_src is 0.
- R6: Format 4 (single register) is laid out as: code, a 4-bit opcode, a 4-bit register, then 3 padding bits. The register is reported on out_src, and out_dst and out_const are 0.
- R7: Format 5 (single constant) is laid out as: code, a 4-bit opcode, then four constant symbols assembled with the first symbol lowest, as in R5. out_src and out_dst are 0.
- R8: Formats 6 (return) and 7 (no-operation) are laid out as: code, then 4 padding bits. out_opcode, out_src, out_dst and out_const are 0.
- R9: Format codes 0 and 1 are invalid. Such a symbol yields a record with out_err high, out_len 1 and all other fields 0 except out_fmt. The next accepted symbol starts a new instruction.
- R10: If any padding bit of format 2, 3, 4, 6 or 7 is non-zero, out_err is high and all fields are still reported. A record with zero padding and a valid code has out_err low.
- R11: A symbol is taken only in a cycle with in_valid and in_ready both high, so idle cycles between symbols do not change the result. out_valid is high for exactly the one cycle after the edge that accepted an instruction's last symbol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_sym carries a symbol |
| in_ready | output | 1 | Decoder accepts a symbol this cycle |
| in_sym | input | 7 | Incoming 7-bit symbol |
| out_valid | output | 1 | One-cycle pulse: the record is complete |
| out_fmt | output | 3 | Format code of the record |
| out_opcode | output | 4 | Opcode field |
| out_src | output | 4 | Source (or single) register number |
| out_dst | output | 4 | Destination register number |
| out_const | output | 28 | Constant, first symbol lowest |
| out_len | output | 3 | Instruction length in symbols |
| out_err | output | 1 | Invalid format code or non-zero padding |

## Verification
Every format is sent with field values that differ from one another. This shows whether a swap of source and destination, or a shift by one bit position, has happened. The constants use a different value in each symbol, so a reversed symbol order gives a different result from the correct one. Invalid codes 0 and 1 are each followed at once by a valid instruction, which shows that decoding starts again on the next symbol. Padding faults are placed in the register-register format and in the one-symbol format. The same register-constant instruction is also sent again with idle cycles and garbage data between its symbols, to show that only handshaked symbols count.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    parameter int SYM_W      = 7;
    parameter int TYPE_W     = 3;
    parameter int OP_W       = 4;
    parameter int REG_W      = 4;
    parameter int CONST_SYMS = 4;
    parameter int RR_SYMS    = 3;
    parameter int RC_SYMS    = 6;
    parameter int R_SYMS     = 2;
    parameter int C_SYMS     = 5;
    parameter int CTL_SYMS   = 1;
    parameter int MAX_SYMS   = 6;

    localparam int CONST_W = SYM_W * CONST_SYMS;
    localparam int BUF_W   = SYM_W * MAX_SYMS;
    localparam int LEN_W   = $clog2(MAX_SYMS + 1);
    localparam int RR_PAD  = RR_SYMS * SYM_W - TYPE_W - OP_W - 2 * REG_W;
    localparam int RC_PAD  = RC_SYMS * SYM_W - CONST_W - TYPE_W - OP_W - REG_W;
    localparam int R_PAD   = R_SYMS * SYM_W - TYPE_W - OP_W - REG_W;
    localparam int CTL_PAD = CTL_SYMS * SYM_W - TYPE_W;

    typedef enum logic [TYPE_W-1:0] {
        FMT_BAD0 = 3'd0,
        FMT_BAD1 = 3'd1,
        FMT_RR   = 3'd2,
        FMT_RC   = 3'd3,
        FMT_R    = 3'd4,
        FMT_C    = 3'd5,
        FMT_RET  = 3'd6,
        FMT_NOP  = 3'd7
    } fmt_e;

    typedef struct packed {
        fmt_e               fmt;
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   src;
        logic [REG_W-1:0]   dst;
        logic [CONST_W-1:0] cval;
        logic [LEN_W-1:0]   len;
        logic               err;
    } rec_t;
endpackage

// File: rtl/bpd_len_lookup.sv
module bpd_len_lookup
    import bpd_pkg::*;
(
    input  logic [TYPE_W-1:0] code_i,
    output logic [LEN_W-1:0]  len_o
);
    always_comb begin
        unique case (fmt_e'(code_i))
            FMT_RR:  len_o = LEN_W'(RR_SYMS);
            FMT_RC:  len_o = LEN_W'(RC_SYMS);
            FMT_R:   len_o = LEN_W'(R_SYMS);
            FMT_C:   len_o = LEN_W'(C_SYMS);
            default: len_o = LEN_W'(CTL_SYMS);
        endcase
    end
endmodule

// File: rtl/bpd_field_extract.sv
module bpd_field_extract
    import bpd_pkg::*;
(
    input  logic [BUF_W-1:0] bits_i,
    output rec_t             rec_o
);
    localparam int TOP          = BUF_W - 1;
    localparam int OP_TOP       = TOP - TYPE_W;
    localparam int R1_TOP       = OP_TOP - OP_W;
    localparam int R2_TOP       = R1_TOP - REG_W;
    localparam int RC_CONST_TOP = R1_TOP - REG_W - RC_PAD;
    localparam int C_CONST_TOP  = OP_TOP - OP_W;

    fmt_e               fmt;
    logic [LEN_W-1:0]   len;
    logic [CONST_W-1:0] rc_c;
    logic [CONST_W-1:0] c_c;

    assign fmt = fmt_e'(bits_i[TOP -: TYPE_W]);

    bpd_len_lookup i_len (
        .code_i (bits_i[TOP -: TYPE_W]),
        .len_o  (len)
    );

    // first received constant symbol lands in the lowest bits
    for (genvar k = 0; k < CONST_SYMS; k++) begin : g_const
        assign rc_c[k*SYM_W +: SYM_W] = bits_i[RC_CONST_TOP - k*SYM_W -: SYM_W];
        assign c_c[k*SYM_W +: SYM_W]  = bits_i[C_CONST_TOP - k*SYM_W -: SYM_W];
    end

    always_comb begin
        logic pad_bad;
        pad_bad = 1'b0;
        rec_o   = '0;
        rec_o.fmt = fmt;
        rec_o.len = len;
        unique case (fmt)
            FMT_RR: begin
                rec_o.op  = bits_i[OP_TOP -: OP_W];
                rec_o.src = bits_i[R1_TOP -: REG_W];
                rec_o.dst = bits_i[R2_TOP -: REG_W];
                pad_bad   = |bits_i[R2_TOP - REG_W -: RR_PAD];
            end
            FMT_RC: begin
                rec_o.op   = bits_i[OP_TOP -: OP_W];
                rec_o.dst  = bits_i[R1_TOP -: REG_W];
                rec_o.cval = rc_c;
                pad_bad    = |bits_i[R1_TOP - REG_W -: RC_PAD];
            end
            FMT_R: begin
                rec_o.op  = bits_i[OP_TOP -: OP_W];
                rec_o.src = bits_i[R1_TOP -: REG_W];
                pad_bad   = |bits_i[R1_TOP - REG_W -: R_PAD];
            end
            FMT_C: begin
                rec_o.op   = bits_i[OP_TOP -: OP_W];
                rec_o.cval = c_c;
            end
            FMT_RET, FMT_NOP: begin
                pad_bad = |bits_i[OP_TOP -: CTL_PAD];
            end
            default: pad_bad = 1'b1;
        endcase
        rec_o.err = pad_bad;
    end
endmodule

// File: rtl/bitpack_decoder.sv
module bitpack_decoder
    import bpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [SYM_W-1:0]   in_sym,
    output logic               out_valid,
    output logic [TYPE_W-1:0]  out_fmt,
    output logic [OP_W-1:0]    out_opcode,
    output logic [REG_W-1:0]   out_src,
    output logic [REG_W-1:0]   out_dst,
    output logic [CONST_W-1:0] out_const,
    output logic [LEN_W-1:0]   out_len,
    output logic               out_err
);
    typedef struct packed {
        logic             ready;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] need;
        logic [BUF_W-1:0] acc;
        logic             ovalid;
        rec_t             rec;
    } state_t;

    state_t           st_d, st_q;
    logic             take;
    logic [LEN_W-1:0] first_len;
    logic [LEN_W-1:0] need_now;
    logic [BUF_W-1:0] acc_next;
    rec_t             ext_rec;

    assign take = in_valid && st_q.ready;

    bpd_len_lookup i_first_len (
        .code_i (in_sym[SYM_W-1 -: TYPE_W]),
        .len_o  (first_len)
    );

    // place the incoming symbol into its slot of the MSB-first window
    always_comb begin
        if (st_q.cnt == '0) begin
            need_now = first_len;
            acc_next = '0;
        end else begin
            need_now = st_q.need;
            acc_next = st_q.acc;
        end
        for (int s = 0; s < MAX_SYMS; s++) begin
            if (st_q.cnt == LEN_W'(s)) begin
                acc_next[BUF_W-1 - s*SYM_W -: SYM_W] = in_sym;
            end
        end
    end

    bpd_field_extract i_extract (
        .bits_i (acc_next),
        .rec_o  (ext_rec)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ready  = 1'b1;
        st_d.ovalid = 1'b0;
        if (take) begin
            if (st_q.cnt + LEN_W'(1) == need_now) begin
                st_d.ovalid = 1'b1;
                st_d.rec    = ext_rec;
                st_d.cnt    = '0;
                st_d.need   = '0;
                st_d.acc    = '0;
            end else begin
                st_d.cnt  = st_q.cnt + LEN_W'(1);
                st_d.need = need_now;
                st_d.acc  = acc_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready   = st_q.ready;
    assign out_valid  = st_q.ovalid;
    assign out_fmt    = st_q.rec.fmt;
    assign out_opcode = st_q.rec.op;
    assign out_src    = st_q.rec.src;
    assign out_dst    = st_q.rec.dst;
    assign out_const  = st_q.rec.cval;
    assign out_len    = st_q.rec.len;
    assign out_err    = st_q.rec.err;

    // R1
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready);

    // R3
    len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6}));

    // R8
    ctl_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt >= 3'd6) |-> (out_len == 3'd1 && out_opcode == '0));

    // R9
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt < 3'd2) |-> (out_err && out_len == 3'd1));

    // R11
    pulse_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < LEN_W'(MAX_SYMS));
endmodule

// File: tb/test_bitpack_decoder.sv
module test_bitpack_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  in_sym = '0;
    logic        in_ready;
    logic        out_valid;
    logic [2:0]  out_fmt;
    logic [3:0]  out_opcode;
    logic [3:0]  out_src;
    logic [3:0]  out_dst;
    logic [27:0] out_const;
    logic [2:0]  out_len;
    logic        out_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bitpack_decoder i_bitpack_decoder (
        .clk, .rst_n, .in_valid, .in_ready, .in_sym,
        .out_valid, .out_fmt, .out_opcode, .out_src, .out_dst,
        .out_const, .out_len, .out_err
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // MSB-first packing of a 42-bit window into symbols
    function automatic logic [41:0] pk_rr(logic [3:0] op, logic [3:0] s, logic [3:0] d, logic [5:0] pad);
        return {3'b010, op, s, d, pad, 21'd0};
    endfunction
    function automatic logic [41:0] pk_rc(logic [3:0] op, logic [3:0] d, logic [27:0] c);
        return {3'b011, op, d, 3'b000, c[6:0], c[13:7], c[20:14], c[27:21]};
    endfunction
    function automatic logic [41:0] pk_r(logic [3:0] op, logic [3:0] r);
        return {3'b100, op, r, 3'b000, 28'd0};
    endfunction
    function automatic logic [41:0] pk_c(logic [3:0] op, logic [27:0] c);
        return {3'b101, op, c[6:0], c[13:7], c[20:14], c[27:21], 7'd0};
    endfunction

    task automatic send(input logic [41:0] v, input int n, input int gap);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) check("R11", "no pulse mid-instruction", 64'(out_valid), 64'd0);
            in_valid = 1'b1;
            in_sym   = v[41 - 7*k -: 7];
            if (k < n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sym   = 7'h7F;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sym   = 7'h55;
    endtask

    task automatic expect_rec(input string req, input logic [2:0] f, input logic [3:0] op,
                              input logic [3:0] s, input logic [3:0] d, input logic [27:0] c,
                              input logic [2:0] len, input logic err);
        check(req, "out_valid", 64'(out_valid), 64'd1);
        check(req, "record {fmt,op,src,dst,const,len,err}",
              64'({out_fmt, out_opcode, out_src, out_dst, out_const, out_len, out_err}),
              64'({f, op, s, d, c, len, err}));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R1", "in_ready in reset", 64'(in_ready), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "in_ready after release", 64'(in_ready), 64'd1);
        check("R1", "out_valid after release", 64'(out_valid), 64'd0);
    endtask

    task automatic t_regreg();
        send(pk_rr(4'h9, 4'h3, 4'hC, 6'd0), 3, 0);
        expect_rec("R4", 3'd2, 4'h9, 4'h3, 4'hC, 28'd0, 3'd3, 1'b0);
        @(negedge clk);
        check("R11", "pulse lasts one cycle", 64'(out_valid), 64'd0);
    endtask

    task automatic t_regconst();
        send(pk_rc(4'h5, 4'hA, 28'h1234567), 6, 0);
        expect_rec("R5", 3'd3, 4'h5, 4'h0, 4'hA, 28'h1234567, 3'd6, 1'b0);
    endtask

    task automatic t_single_reg();
        send(pk_r(4'hE, 4'h6), 2, 0);
        expect_rec("R6", 3'd4, 4'hE, 4'h6, 4'h0, 28'd0, 3'd2, 1'b0);
    endtask

    task automatic t_single_const();
        send(pk_c(4'h2, 28'hABCDE1F), 5, 0);
        expect_rec("R7", 3'd5, 4'h2, 4'h0, 4'h0, 28'hABCDE1F, 3'd5, 1'b0);
    endtask

    task automatic t_ret_nop();
        send({7'b1100000, 35'd0}, 1, 0);
        expect_rec("R8", 3'd6, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b0);
        send({7'b1110000, 35'd0}, 1, 0);
        expect_rec("R8", 3'd7, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b0);
    endtask

    task automatic t_bad_code();
        send({7'b0000000, 35'd0}, 1, 0);
        expect_rec("R9", 3'd0, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b1);
        send({7'b0011010, 35'd0}, 1, 0);
        expect_rec("R9", 3'd1, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b1);
        send(pk_r(4'h1, 4'hF), 2, 0);
        expect_rec("R9", 3'd4, 4'h1, 4'hF, 4'h0, 28'd0, 3'd2, 1'b0);
    endtask

    task automatic t_bad_pad();
        send(pk_rr(4'h7, 4'h1, 4'h2, 6'b000100), 3, 0);
        expect_rec("R10", 3'd2, 4'h7, 4'h1, 4'h2, 28'd0, 3'd3, 1'b1);
        send({7'b1100101, 35'd0}, 1, 0);
        expect_rec("R10", 3'd6, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b1);
        send({7'b1110000, 35'd0}, 1, 0);
        expect_rec("R10", 3'd7, 4'h0, 4'h0, 4'h0, 28'd0, 3'd1, 1'b0);
    endtask

    task automatic t_gaps();
        send(pk_rc(4'hB, 4'h4, 28'h0F1E2D3), 6, 3);
        expect_rec("R11", 3'd3, 4'hB, 4'h0, 4'h4, 28'h0F1E2D3, 3'd6, 1'b0);
        check("R2", "format code from top bits", 64'(out_fmt), 64'd3);
    endtask

    initial begin
        t_reset();
        t_regreg();
        t_regconst();
        t_single_reg();
        t_single_const();
        t_ret_nop();
        t_bad_code();
        t_bad_pad();
        t_gaps();
        check("R3", "length of last record", 64'(out_len), 64'd6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule